// File: doc/BRIEF.md
# Keyed Clock-Control Register Bank

This block is the software-facing register file of a clock manager. It decodes a 0x2000-byte window of 32-bit words and holds the configuration words for a set of PLLs, their output channels and a set of clock selectors with dividers. It also tells the attached clock logic when to re-evaluate. The clock datapaths are not part of this block. They read the stored words from the `*_q` output buses and act on the one-cycle update strobes.

Every write must carry a fixed key in its top byte. A write without the key is dropped, with no change to storage and no strobe. A keyed write is stored with the key byte cleared. A read-only status word reports live lock state for each PLL. Lock state is computed from two configuration bits that sit in two different registers.

Top module: `clkmgr_regif`

## Requirements
- R1: A write whose bits 31:24 differ from 0x5A changes no stored word and raises no update strobe.
- R2: A keyed write stores the data with bits 31:24 forced to zero. A later read of that word, and the matching `*_q` output slice, return the stored value.
- R3: Only full-word, word-aligned accesses are honoured. An access needs `req_be` = 4'hF and `req_addr[1:0]` = 0. Any other write is ignored, and any other read returns zero. Byte lane 0 (`req_be[0]`) carries bits 7:0.
- R4: Byte address map (word index = offset / 4). PLL config p is at 0x100+4p. The lock status word is at 0x118. Selector control m is at 0x200+8m, and its divider is at the next word, 0x204+8m. PLL analog word p is at 0x1000+4p. Channel c is at 0x1100+4c.
- R5: After reset, every PLL analog word reads 0x0001_0000 (power-down set) and all other words read zero.
- R6: The lock word reads PLL p's status in bit 8+p. A PLL is locked when bit 8 (analog reset) of its config word and bit 16 (power-down) of its analog word are both zero. The lock word is live and read-only: a write to it changes nothing and raises no strobe.
- R7: A keyed write to selector m's control word or divider word pulses `mux_upd[m]` for exactly one cycle, in the cycle after the write.
- R8: A keyed write to PLL config p pulses `pll_upd[p]` and `ch_upd[c]` for every channel c whose parent is p (parent = c mod number of PLLs). A keyed write to PLL analog word p pulses only `pll_upd[p]`.
- R9: A keyed write to channel c pulses only `ch_upd[c]`.
- R10: Offsets outside the map read as zero and ignore writes.
- R11: `rd_valid` rises for one cycle in the cycle after each read request, and `rd_data` holds the result in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data including key byte |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| pll_upd | output | NUM_PLL | PLL re-evaluate strobes |
| ch_upd | output | NUM_CH | Channel re-evaluate strobes |
| mux_upd | output | NUM_MUX | Selector re-evaluate strobes |
| pll_lock | output | NUM_PLL | Live lock status |
| pll_cfg_q | output | NUM_PLL*32 | Stored PLL config words |
| pll_ana_q | output | NUM_PLL*32 | Stored PLL analog words |
| ch_cfg_q | output | NUM_CH*32 | Stored channel words |
| mux_ctl_q | output | NUM_MUX*32 | Stored selector control words |
| mux_div_q | output | NUM_MUX*32 | Stored selector divider words |

## Verification
A single keyed write to a PLL config word raises the PLL strobe and the strobes of all its child channels in the same cycle. The bench writes PLL 0 (children 0 and 5) and PLL 4 (child 4 only) and compares the whole strobe vector, PLL, channel and selector fields together, against the parent rule. A write to a PLL analog word must raise the PLL strobe alone, even though the PLL's lock state can change in that same cycle. This case is judged by comparing the strobe vector first, then reading the lock word. The lock expectation follows from the two controlling bits.

// File: rtl/cm_regs_pkg.sv
package cm_regs_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned KEY_HI      = 31;
  localparam int unsigned KEY_LO      = 24;
  localparam logic [7:0]  KEY_MAGIC   = 8'h5A;

  // word indices (byte offset / 4)
  localparam int unsigned PLLCFG_BASE = 'h040;
  localparam int unsigned LOCK_WORD   = 'h046;
  localparam int unsigned MUX_BASE    = 'h080;
  localparam int unsigned PLLANA_BASE = 'h400;
  localparam int unsigned CHAN_BASE   = 'h440;

  localparam int unsigned ARST_BIT    = 8;
  localparam int unsigned PDN_BIT     = 16;
  localparam int unsigned LOCK_SHIFT  = 8;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_PLL_CFG, TGT_PLL_ANA, TGT_CHAN, TGT_MUX_CTL, TGT_MUX_DIV, TGT_LOCK
  } tgt_kind_e;

  typedef struct packed {
    tgt_kind_e  kind;
    logic [7:0] idx;
  } tgt_t;

  function automatic logic key_ok(input logic [WORD_W-1:0] d);
    return d[KEY_HI:KEY_LO] == KEY_MAGIC;
  endfunction

  function automatic logic [WORD_W-1:0] key_strip(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    r = d;
    r[KEY_HI:KEY_LO] = '0;
    return r;
  endfunction

  function automatic int unsigned chan_parent(input int unsigned c, input int unsigned n_pll);
    return c % n_pll;
  endfunction

  function automatic logic pll_is_locked(input logic [WORD_W-1:0] cfg,
                                         input logic [WORD_W-1:0] ana);
    return !cfg[ARST_BIT] && !ana[PDN_BIT];
  endfunction

endpackage

// File: rtl/cm_addr_decode.sv
module cm_addr_decode
  import cm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned NUM_PLL = 5,
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned NUM_MUX = 4
) (
  input  logic [ADDR_W-3:0] widx,
  output tgt_t              tgt
);

  logic [31:0] w;
  logic [31:0] moff;

  always_comb begin
    w        = 32'(widx);
    moff     = w - MUX_BASE;
    tgt.kind = TGT_NONE;
    tgt.idx  = '0;
    if (w >= PLLCFG_BASE && w < PLLCFG_BASE + NUM_PLL) begin
      tgt.kind = TGT_PLL_CFG;
      tgt.idx  = 8'(w - PLLCFG_BASE);
    end else if (w == LOCK_WORD) begin
      tgt.kind = TGT_LOCK;
    end else if (w >= MUX_BASE && w < MUX_BASE + 2 * NUM_MUX) begin
      tgt.kind = moff[0] ? TGT_MUX_DIV : TGT_MUX_CTL;
      tgt.idx  = 8'(moff >> 1);
    end else if (w >= PLLANA_BASE && w < PLLANA_BASE + NUM_PLL) begin
      tgt.kind = TGT_PLL_ANA;
      tgt.idx  = 8'(w - PLLANA_BASE);
    end else if (w >= CHAN_BASE && w < CHAN_BASE + NUM_CH) begin
      tgt.kind = TGT_CHAN;
      tgt.idx  = 8'(w - CHAN_BASE);
    end
  end

endmodule

// File: rtl/cm_reg_bank.sv
module cm_reg_bank
  import cm_regs_pkg::*;
#(
  parameter int unsigned NUM_PLL = 5,
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned NUM_MUX = 4,
  parameter logic [31:0] ANA_RST = 32'h0001_0000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  tgt_t                           tgt,
  input  logic [WORD_W-1:0]              wval,
  output logic [NUM_PLL-1:0][WORD_W-1:0] cfg_q,
  output logic [NUM_PLL-1:0][WORD_W-1:0] ana_q,
  output logic [NUM_CH-1:0][WORD_W-1:0]  ch_q,
  output logic [NUM_MUX-1:0][WORD_W-1:0] mctl_q,
  output logic [NUM_MUX-1:0][WORD_W-1:0] mdiv_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < int'(NUM_PLL); p++) begin
        cfg_q[p] <= '0;
        ana_q[p] <= ANA_RST;
      end
    end else if (we) begin
      for (int p = 0; p < int'(NUM_PLL); p++) begin
        if (tgt.idx == 8'(p) && tgt.kind == TGT_PLL_CFG) cfg_q[p] <= wval;
        if (tgt.idx == 8'(p) && tgt.kind == TGT_PLL_ANA) ana_q[p] <= wval;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < int'(NUM_CH); c++) ch_q[c] <= '0;
    end else if (we && tgt.kind == TGT_CHAN) begin
      for (int c = 0; c < int'(NUM_CH); c++)
        if (tgt.idx == 8'(c)) ch_q[c] <= wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < int'(NUM_MUX); m++) begin
        mctl_q[m] <= '0;
        mdiv_q[m] <= '0;
      end
    end else if (we) begin
      for (int m = 0; m < int'(NUM_MUX); m++) begin
        if (tgt.idx == 8'(m) && tgt.kind == TGT_MUX_CTL) mctl_q[m] <= wval;
        if (tgt.idx == 8'(m) && tgt.kind == TGT_MUX_DIV) mdiv_q[m] <= wval;
      end
    end
  end

endmodule

// File: rtl/cm_upd_strobe.sv
module cm_upd_strobe
  import cm_regs_pkg::*;
#(
  parameter int unsigned NUM_PLL = 5,
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned NUM_MUX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  tgt_t               tgt,
  output logic [NUM_PLL-1:0] pll_upd,
  output logic [NUM_CH-1:0]  ch_upd,
  output logic [NUM_MUX-1:0] mux_upd
);

  logic [NUM_PLL-1:0] cfg_hit;
  logic [NUM_PLL-1:0] pll_hit;
  logic [NUM_CH-1:0]  ch_hit;
  logic [NUM_MUX-1:0] mux_hit;

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    assign cfg_hit[p] = we && tgt.kind == TGT_PLL_CFG && tgt.idx == 8'(p);
    assign pll_hit[p] = cfg_hit[p] ||
                        (we && tgt.kind == TGT_PLL_ANA && tgt.idx == 8'(p));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned PAR = chan_parent(c, NUM_PLL);
    assign ch_hit[c] = cfg_hit[PAR] ||
                       (we && tgt.kind == TGT_CHAN && tgt.idx == 8'(c));
  end

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
    assign mux_hit[m] = we && tgt.idx == 8'(m) &&
                        (tgt.kind == TGT_MUX_CTL || tgt.kind == TGT_MUX_DIV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_upd <= '0;
      ch_upd  <= '0;
      mux_upd <= '0;
    end else begin
      pll_upd <= pll_hit;
      ch_upd  <= ch_hit;
      mux_upd <= mux_hit;
    end
  end

endmodule

// File: rtl/clkmgr_regif.sv
module clkmgr_regif
  import cm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned NUM_PLL = 5,
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned NUM_MUX = 4,
  parameter logic [31:0] ANA_RST = 32'h0001_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [3:0]                req_be,
  input  logic [31:0]               req_wdata,
  output logic                      rd_valid,
  output logic [31:0]               rd_data,
  output logic [NUM_PLL-1:0]        pll_upd,
  output logic [NUM_CH-1:0]         ch_upd,
  output logic [NUM_MUX-1:0]        mux_upd,
  output logic [NUM_PLL-1:0]        pll_lock,
  output logic [NUM_PLL*32-1:0]     pll_cfg_q,
  output logic [NUM_PLL*32-1:0]     pll_ana_q,
  output logic [NUM_CH*32-1:0]      ch_cfg_q,
  output logic [NUM_MUX*32-1:0]     mux_ctl_q,
  output logic [NUM_MUX*32-1:0]     mux_div_q
);

  localparam int unsigned WIDX_W = ADDR_W - 2;

  tgt_t                           tgt;
  logic                           acc_full;
  logic                           key_good;
  logic                           tgt_rw;
  logic                           wr_accept;
  logic                           rd_fire;
  logic [WORD_W-1:0]              rd_word;
  logic [WORD_W-1:0]              lock_word;
  logic [NUM_PLL-1:0][WORD_W-1:0] cfg_q, ana_q;
  logic [NUM_CH-1:0][WORD_W-1:0]  ch_q;
  logic [NUM_MUX-1:0][WORD_W-1:0] mctl_q, mdiv_q;

  cm_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH), .NUM_MUX(NUM_MUX)
  ) u_dec (
    .widx (req_addr[ADDR_W-1:2]),
    .tgt  (tgt)
  );

  assign acc_full  = (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
  assign key_good  = key_ok(req_wdata);
  assign tgt_rw    = (tgt.kind != TGT_NONE) && (tgt.kind != TGT_LOCK);
  assign wr_accept = req_valid && req_write && acc_full && key_good && tgt_rw;
  assign rd_fire   = req_valid && !req_write;

  cm_reg_bank #(
    .NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH), .NUM_MUX(NUM_MUX), .ANA_RST(ANA_RST)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_accept),
    .tgt    (tgt),
    .wval   (key_strip(req_wdata)),
    .cfg_q  (cfg_q),
    .ana_q  (ana_q),
    .ch_q   (ch_q),
    .mctl_q (mctl_q),
    .mdiv_q (mdiv_q)
  );

  cm_upd_strobe #(
    .NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH), .NUM_MUX(NUM_MUX)
  ) u_strb (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_accept),
    .tgt     (tgt),
    .pll_upd (pll_upd),
    .ch_upd  (ch_upd),
    .mux_upd (mux_upd)
  );

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_lock
    assign pll_lock[p] = pll_is_locked(cfg_q[p], ana_q[p]);
  end

  assign lock_word = WORD_W'(pll_lock) << LOCK_SHIFT;

  always_comb begin
    rd_word = '0;
    unique case (tgt.kind)
      TGT_LOCK: rd_word = lock_word;
      TGT_PLL_CFG, TGT_PLL_ANA:
        for (int p = 0; p < int'(NUM_PLL); p++)
          if (tgt.idx == 8'(p))
            rd_word = (tgt.kind == TGT_PLL_CFG) ? cfg_q[p] : ana_q[p];
      TGT_CHAN:
        for (int c = 0; c < int'(NUM_CH); c++)
          if (tgt.idx == 8'(c)) rd_word = ch_q[c];
      TGT_MUX_CTL, TGT_MUX_DIV:
        for (int m = 0; m < int'(NUM_MUX); m++)
          if (tgt.idx == 8'(m))
            rd_word = (tgt.kind == TGT_MUX_CTL) ? mctl_q[m] : mdiv_q[m];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      rd_data  <= (rd_fire && acc_full) ? rd_word : '0;
    end
  end

  assign pll_cfg_q = cfg_q;
  assign pll_ana_q = ana_q;
  assign ch_cfg_q  = ch_q;
  assign mux_ctl_q = mctl_q;
  assign mux_div_q = mdiv_q;

endmodule

// File: rtl/clkmgr_regif_chk.sv
module clkmgr_regif_chk
  import cm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned NUM_PLL = 5,
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned NUM_MUX = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [ADDR_W-1:0]     req_addr,
  input logic [3:0]            req_be,
  input logic [31:0]           req_wdata,
  input logic                  wr_accept,
  input logic                  rd_valid,
  input logic [31:0]           rd_data,
  input logic [NUM_PLL-1:0]    pll_upd,
  input logic [NUM_CH-1:0]     ch_upd,
  input logic [NUM_MUX-1:0]    mux_upd,
  input logic [NUM_PLL-1:0]    pll_lock,
  input logic [NUM_PLL*32-1:0] pll_cfg_q,
  input logic [NUM_PLL*32-1:0] pll_ana_q,
  input logic [NUM_CH*32-1:0]  ch_cfg_q,
  input logic [NUM_MUX*32-1:0] mux_ctl_q,
  input logic [NUM_MUX*32-1:0] mux_div_q
);

  logic        full_acc;
  logic        wr_keyed;
  logic [31:0] widx;

  assign full_acc = req_be == 4'hF && req_addr[1:0] == 2'b00;
  assign wr_keyed = req_valid && req_write && full_acc && req_wdata[31:24] == KEY_MAGIC;
  assign widx     = 32'(req_addr) >> 2;

  // R1
  p_bad_key_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_wdata[31:24] != KEY_MAGIC)
      |=> (pll_upd == '0 && ch_upd == '0 && mux_upd == '0));

  p_bad_key_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_wdata[31:24] != KEY_MAGIC)
      |=> ($stable(pll_cfg_q) && $stable(pll_ana_q) && $stable(ch_cfg_q)
           && $stable(mux_ctl_q) && $stable(mux_div_q)));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> (pll_upd == '0 && ch_upd == '0 && mux_upd == '0));

  // R2
  p_key_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[31:24] == 8'h00);

  // R3
  p_partial_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !full_acc) |=> (pll_upd == '0 && ch_upd == '0 && mux_upd == '0
                                  && rd_data == '0));

  // R6
  p_lock_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && full_acc && widx == LOCK_WORD)
      |=> rd_data == (32'($past(pll_lock)) << LOCK_SHIFT));

  // R11
  p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  // R8: analog write touches no channel
  p_ana_no_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_keyed && widx >= PLLANA_BASE && widx < PLLANA_BASE + NUM_PLL) |=> ch_upd == '0);

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux_chk
    // R7
    p_mux_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_keyed && (widx == MUX_BASE + 2 * m || widx == MUX_BASE + 2 * m + 1))
        |=> mux_upd[m]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    // R8
    p_chan_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_keyed && widx == PLLCFG_BASE + (c % NUM_PLL)) |=> ch_upd[c]);
  end

endmodule

bind clkmgr_regif clkmgr_regif_chk #(
  .ADDR_W(ADDR_W), .NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH), .NUM_MUX(NUM_MUX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
  .wr_accept(wr_accept), .rd_valid(rd_valid), .rd_data(rd_data),
  .pll_upd(pll_upd), .ch_upd(ch_upd), .mux_upd(mux_upd), .pll_lock(pll_lock),
  .pll_cfg_q(pll_cfg_q), .pll_ana_q(pll_ana_q), .ch_cfg_q(ch_cfg_q),
  .mux_ctl_q(mux_ctl_q), .mux_div_q(mux_div_q)
);

// File: tb/clkmgr_regif_bench.sv
module clkmgr_regif_bench;

  localparam int NP = 5;
  localparam int NC = 6;
  localparam int NM = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [12:0]   req_addr;
  logic [3:0]    req_be;
  logic [31:0]   req_wdata;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NP-1:0] pll_upd, pll_lock;
  logic [NC-1:0] ch_upd;
  logic [NM-1:0] mux_upd;
  logic [NP*32-1:0] pll_cfg_q, pll_ana_q;
  logic [NC*32-1:0] ch_cfg_q;
  logic [NM*32-1:0] mux_ctl_q, mux_div_q;

  always #5 clk = ~clk;

  clkmgr_regif u_clkmgr_regif (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .pll_upd(pll_upd), .ch_upd(ch_upd),
    .mux_upd(mux_upd), .pll_lock(pll_lock), .pll_cfg_q(pll_cfg_q),
    .pll_ana_q(pll_ana_q), .ch_cfg_q(ch_cfg_q), .mux_ctl_q(mux_ctl_q),
    .mux_div_q(mux_div_q)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      exp_t e;
      if (sb.size() == 0) check("R11 unexpected rd_valid", 32'd1, 32'd0);
      else begin
        e = sb.pop_front();
        check(e.tag, rd_data, e.exp);
      end
    end
  end

  // driver: write, then compare all strobes in the following cycle
  task automatic wchk(input string tag, input logic [12:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [NP-1:0] ep,
                      input logic [NC-1:0] ec, input logic [NM-1:0] em);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    check(tag, 32'({pll_upd, ch_upd, mux_upd}), 32'({ep, ec, em}));
    req_valid = 1'b0;
  endtask

  // driver: read request, expected result queued for the monitor
  task automatic rd(input string tag, input logic [12:0] a, input logic [3:0] be,
                    input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be; req_wdata = '0;
    sb.push_back('{exp, tag});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R5 reset strobes", 32'({pll_upd, ch_upd, mux_upd}), 32'd0);
    rst_n = 1'b1;
    check("R5 reset ana3 port", pll_ana_q[3*32 +: 32], 32'h0001_0000);
    rd("R5 reset ana0", 13'h1000, 4'hF, 32'h0001_0000);
    rd("R5 reset mux ctl0", 13'h0200, 4'hF, 32'h0);
    rd("R5 R6 reset lock", 13'h0118, 4'hF, 32'h0);

    // R8: analog write, PLL strobe alone; lock follows (R6)
    wchk("R8 ana2 strobes", 13'h1008, 32'h5A00_0000, 4'hF, 5'b00100, 6'b0, 4'b0);
    rd("R6 lock pll2", 13'h0118, 4'hF, 32'h0000_0400);

    // R1: wrong key
    wchk("R1 bad key strobes", 13'h100C, 32'hA500_0000, 4'hF, 5'b0, 6'b0, 4'b0);
    rd("R1 ana3 kept", 13'h100C, 4'hF, 32'h0001_0000);
    check("R1 ana3 port kept", pll_ana_q[3*32 +: 32], 32'h0001_0000);

    // R2 R7 R4: selector control and its divider at +4
    wchk("R7 mux ctl1 strobe", 13'h0208, 32'h5A00_1234, 4'hF, 5'b0, 6'b0, 4'b0010);
    rd("R2 mux ctl1 readback", 13'h0208, 4'hF, 32'h0000_1234);
    check("R2 mux ctl1 port", mux_ctl_q[1*32 +: 32], 32'h0000_1234);
    wchk("R7 mux div1 strobe", 13'h020C, 32'h5AFF_FFFF, 4'hF, 5'b0, 6'b0, 4'b0010);
    rd("R2 R4 mux div1 readback", 13'h020C, 4'hF, 32'h00FF_FFFF);

    // R8: PLL config write fans out to child channels 0 and 5
    wchk("R8 cfg0 fanout", 13'h0100, 32'h5A00_0100, 4'hF, 5'b00001, 6'b100001, 4'b0);
    wchk("R8 ana0 alone", 13'h1000, 32'h5A00_0000, 4'hF, 5'b00001, 6'b0, 4'b0);
    rd("R6 lock held by analog reset", 13'h0118, 4'hF, 32'h0000_0400);
    wchk("R8 cfg0 clear fanout", 13'h0100, 32'h5A00_0000, 4'hF, 5'b00001, 6'b100001, 4'b0);
    rd("R6 lock pll0 and pll2", 13'h0118, 4'hF, 32'h0000_0500);
    wchk("R8 cfg4 fanout", 13'h0110, 32'h5A00_0000, 4'hF, 5'b10000, 6'b010000, 4'b0);

    // R9: channel write
    wchk("R9 chan3 strobe", 13'h110C, 32'h5A00_00AB, 4'hF, 5'b0, 6'b001000, 4'b0);
    rd("R9 chan3 readback", 13'h110C, 4'hF, 32'h0000_00AB);

    // R3: partial and misaligned
    wchk("R3 partial write", 13'h0200, 32'h5A00_00FF, 4'h3, 5'b0, 6'b0, 4'b0);
    wchk("R3 misaligned write", 13'h0201, 32'h5A00_00FF, 4'hF, 5'b0, 6'b0, 4'b0);
    rd("R3 ctl0 unchanged", 13'h0200, 4'hF, 32'h0);
    rd("R3 partial read zero", 13'h0208, 4'h1, 32'h0);
    rd("R3 misaligned read zero", 13'h0209, 4'hF, 32'h0);

    // R10: unmapped
    wchk("R10 unmapped write", 13'h0300, 32'h5A00_0077, 4'hF, 5'b0, 6'b0, 4'b0);
    rd("R10 unmapped read", 13'h0300, 4'hF, 32'h0);
    rd("R10 top of window", 13'h1FFC, 4'hF, 32'h0);

    // R6: lock word read-only
    wchk("R6 lock write quiet", 13'h0118, 32'h5A00_00FF, 4'hF, 5'b0, 6'b0, 4'b0);
    rd("R6 lock unchanged", 13'h0118, 4'hF, 32'h0000_0500);

    repeat (3) @(negedge clk);
    check("R11 queue drained", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule